// File: doc/BRIEF.md
# Wireless Beacon Timer Array

This block holds five periodic compare timers that share one free-running microsecond timestamp. Each armed timer emits a one-cycle pulse when the timestamp equals its next-event value and then moves that value forward by its own period. The five events are target beacon time, a DMA beacon alert, a software beacon alert, a traffic-map wake and a delivery-traffic-map wake. The first three serve an access point or ad-hoc node. The last two serve a power-saving station.

Software drives a single write port. Raw writes set any timer's next-event value or period and the enable mask. Two setup commands compute a whole configuration in hardware. The access-point command derives the beacon time and both lead alerts from eighth-of-a-time-unit counts and can clear the timestamp. The station command derives the early wake times, the wake periods and the alignment of the traffic-map wake from whole time-unit counts. The timestamp advances on a per-microsecond tick input and can also be cleared from a dedicated input.

Top module: `beacon_timer_array`

## Requirements
- R1: The timestamp `tsf_o` resets to 0 and increments by one modulo 2^32 in each cycle that `us_tick_i` is high. It holds when the tick is low. A clear (`tsf_clear_i`, or the access-point command with bit 0 set) forces it to 0 in the next cycle, and a clear takes priority over a tick.
- R2: The timers use index 0 beacon, 1 DMA alert, 2 software alert, 3 traffic-map wake and 4 delivery-traffic-map wake, and bit i of `evt_pulse_o` belongs to timer i. An enabled timer drives its bit high for exactly the cycle in which `tsf_o` equals its next-event value. In that same cycle the next-event value gains the timer's period.
- R3: A timer whose enable bit is clear never pulses, and its next-event value holds.
- R4: A write to address i (0..4) loads timer i's next-event value from the following cycle. A write to address 5+i loads its period. If the write coincides with a match, the pulse is still emitted and the written value replaces the advanced one. A write to address 10 sets the enable mask from bits 4:0.
- R5: Address 11 holds the DMA lead in bits 15:0 and the software lead in bits 31:16, both in microseconds. Address 12 holds a period correction in microseconds in bits 15:0. A write to address 14 takes the next beacon N from bits 31:16, in eighths of a time unit (128 us). It sets the beacon next-event to N*128, the DMA alert to N*128 minus the DMA lead, and the software alert to N*128 minus the software lead.
- R6: The same address-14 write takes P from bits 15:1 and loads timers 0, 1 and 2 with the period P*128 + correction.
- R7: The address-14 write clears the timestamp when bit 0 is set. It sets enable bits 0, 1 and 2 and leaves bits 3 and 4 unchanged.
- R8: Address 13 holds the station's next beacon B in bits 15:0 and next delivery-traffic-map time D in bits 31:16, both in time units (1024 us). A write to address 15 takes the interval I from bits 9:0, the delivery period Q from bits 19:10 and the sleep duration S from bits 29:20, all in time units. It clears enables 1 and 2 and sets enables 0, 3 and 4. It loads the beacon timer with next-event B*1024 and period I*1024, and the DMA alert period with I*1024.
- R9: The address-15 write sets the delivery wake to (D-3)*1024 and the traffic-map wake to (T-3)*1024, where T is D when the two wake periods are equal and B otherwise.
- R10: The traffic-map wake period is max(I,S)*1024 and the delivery wake period is max(Q,S)*1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| us_tick_i | input | 1 | One-cycle pulse per microsecond that advances the timestamp |
| tsf_clear_i | input | 1 | Clears the timestamp to zero |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 32 | Write data |
| evt_pulse_o | output | 5 | Event pulses, bit i for timer i |
| tsf_o | output | 32 | Current timestamp in microseconds |

## Verification
The embedded properties check on every cycle how the timestamp steps and clears, that a matching timer advances by exactly its period, that a disabled timer's next-event value stays put, that a raw load appears one cycle later, and the enable mask left by each setup command. The exact event times only show in the bench scenarios. These cover the lead offsets before the beacon, the fractional period correction, the three-unit early wake, the max-with-sleep period rule and the alignment of the traffic-map wake to the delivery wake. The bench also uses a re-enable after a timestamp clear to show that a disabled timer kept its value.

// File: rtl/bta_pkg.sv
package bta_pkg;
  localparam int TSF_W   = 32;
  localparam int NUM_TMR = 5;
  localparam int ADDR_W  = 4;

  localparam int IDX_BCN  = 0;
  localparam int IDX_DMA  = 1;
  localparam int IDX_SWA  = 2;
  localparam int IDX_TIM  = 3;
  localparam int IDX_DTIM = 4;

  localparam logic [ADDR_W-1:0] A_NEXT0 = 4'd0;
  localparam logic [ADDR_W-1:0] A_PER0  = 4'd5;
  localparam logic [ADDR_W-1:0] A_ENA   = 4'd10;
  localparam logic [ADDR_W-1:0] A_LEAD  = 4'd11;
  localparam logic [ADDR_W-1:0] A_CORR  = 4'd12;
  localparam logic [ADDR_W-1:0] A_STIME = 4'd13;
  localparam logic [ADDR_W-1:0] A_APGO  = 4'd14;
  localparam logic [ADDR_W-1:0] A_STAGO = 4'd15;

  localparam int TU_SHIFT    = 10;
  localparam int EIGHT_SHIFT = 7;
  localparam int SLOP_TU     = 3;
  localparam int STA_FW      = 10;
endpackage

// File: rtl/bta_tsf_counter.sv
module bta_tsf_counter #(
  parameter int W = bta_pkg::TSF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         clr_i,
  output logic [W-1:0] tsf_o
);
  logic [W-1:0] tsf_q, tsf_d;
  logic         tsf_ce;

  always_comb begin
    tsf_ce = clr_i | tick_i;
    if (clr_i) tsf_d = '0;
    else       tsf_d = tsf_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tsf_q <= '0;
    else if (tsf_ce) tsf_q <= tsf_d;
  end

  assign tsf_o = tsf_q;

  assert_tsf_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !clr_i) |=> tsf_q == $past(tsf_q) + 1'b1);
  assert_tsf_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> tsf_q == '0);
  assert_tsf_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(tsf_q));
endmodule

// File: rtl/bta_event_timer.sv
module bta_event_timer #(
  parameter int W = bta_pkg::TSF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] tsf_i,
  input  logic         load_next_i,
  input  logic [W-1:0] next_val_i,
  input  logic         load_per_i,
  input  logic [W-1:0] per_val_i,
  output logic         hit_o
);
  logic [W-1:0] next_q, next_d, per_q, per_d;
  logic         hit, next_ce;

  always_comb begin
    hit     = en_i && (tsf_i == next_q);
    next_ce = load_next_i | hit;
    if (load_next_i) next_d = next_val_i;
    else             next_d = next_q + per_q;
    per_d = per_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0;
      per_q  <= '0;
    end else begin
      if (next_ce)    next_q <= next_d;
      if (load_per_i) per_q  <= per_d;
    end
  end

  assign hit_o = hit;

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tsf_i == next_q && !load_next_i) |=> next_q == $past(next_q) + $past(per_q));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !load_next_i) |=> $stable(next_q));
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_next_i |=> next_q == $past(next_val_i));
endmodule

// File: rtl/bta_cfg_decode.sv
module bta_cfg_decode
  import bta_pkg::*;
#(
  parameter int W = TSF_W,
  parameter int N = NUM_TMR
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [W-1:0]          wr_data_i,
  output logic [N-1:0]          load_next_o,
  output logic [N-1:0][W-1:0]   next_val_o,
  output logic [N-1:0]          load_per_o,
  output logic [N-1:0][W-1:0]   per_val_o,
  output logic [N-1:0]          en_o,
  output logic                  tsf_clr_o
);
  localparam int HW = W / 2;
  localparam logic [N-1:0] AP_SET   = N'(7);
  localparam logic [N-1:0] STA_CLR  = N'(6);
  localparam logic [N-1:0] STA_SET  = N'(25);

  logic [N-1:0]  en_q, en_d;
  logic [W-1:0]  lead_q, lead_d, stime_q, stime_d;
  logic [HW-1:0] corr_q, corr_d;
  logic          en_ce, lead_ce, corr_ce, stime_ce;

  logic [W-1:0]  ap_base, ap_per;
  logic [W-1:0]  s_iv, s_dp, s_sl, s_bi, s_dd, s_nb, s_nd, s_nt;

  always_comb begin
    ap_base = W'(wr_data_i[W-1:HW]) << EIGHT_SHIFT;
    ap_per  = (W'(wr_data_i[HW-1:1]) << EIGHT_SHIFT) + W'(corr_q);
    s_iv = W'(wr_data_i[STA_FW-1:0]);
    s_dp = W'(wr_data_i[2*STA_FW-1:STA_FW]);
    s_sl = W'(wr_data_i[3*STA_FW-1:2*STA_FW]);
    s_bi = (s_sl > s_iv) ? s_sl : s_iv;
    s_dd = (s_sl > s_dp) ? s_sl : s_dp;
    s_nb = W'(stime_q[HW-1:0]);
    s_nd = W'(stime_q[W-1:HW]);
    s_nt = (s_bi == s_dd) ? s_nd : s_nb;
  end

  always_comb begin
    load_next_o = '0;
    load_per_o  = '0;
    next_val_o  = '0;
    per_val_o   = '0;
    tsf_clr_o   = 1'b0;
    en_d        = en_q;
    lead_d      = wr_data_i;
    corr_d      = wr_data_i[HW-1:0];
    stime_d     = wr_data_i;
    en_ce       = 1'b0;
    lead_ce     = wr_en_i && (wr_addr_i == A_LEAD);
    corr_ce     = wr_en_i && (wr_addr_i == A_CORR);
    stime_ce    = wr_en_i && (wr_addr_i == A_STIME);
    for (int i = 0; i < N; i++) begin
      if (wr_en_i && wr_addr_i == A_NEXT0 + ADDR_W'(i)) begin
        load_next_o[i] = 1'b1;
        next_val_o[i]  = wr_data_i;
      end
      if (wr_en_i && wr_addr_i == A_PER0 + ADDR_W'(i)) begin
        load_per_o[i] = 1'b1;
        per_val_o[i]  = wr_data_i;
      end
    end
    if (wr_en_i && wr_addr_i == A_ENA) begin
      en_ce = 1'b1;
      en_d  = wr_data_i[N-1:0];
    end
    if (wr_en_i && wr_addr_i == A_APGO) begin
      en_ce = 1'b1;
      en_d  = en_q | AP_SET;
      tsf_clr_o = wr_data_i[0];
      load_next_o[IDX_BCN] = 1'b1;
      load_next_o[IDX_DMA] = 1'b1;
      load_next_o[IDX_SWA] = 1'b1;
      next_val_o[IDX_BCN]  = ap_base;
      next_val_o[IDX_DMA]  = ap_base - W'(lead_q[HW-1:0]);
      next_val_o[IDX_SWA]  = ap_base - W'(lead_q[W-1:HW]);
      for (int i = IDX_BCN; i <= IDX_SWA; i++) begin
        load_per_o[i] = 1'b1;
        per_val_o[i]  = ap_per;
      end
    end
    if (wr_en_i && wr_addr_i == A_STAGO) begin
      en_ce = 1'b1;
      en_d  = (en_q & ~STA_CLR) | STA_SET;
      load_next_o[IDX_BCN]  = 1'b1;
      load_next_o[IDX_TIM]  = 1'b1;
      load_next_o[IDX_DTIM] = 1'b1;
      next_val_o[IDX_BCN]   = s_nb << TU_SHIFT;
      next_val_o[IDX_TIM]   = (s_nt - W'(SLOP_TU)) << TU_SHIFT;
      next_val_o[IDX_DTIM]  = (s_nd - W'(SLOP_TU)) << TU_SHIFT;
      load_per_o[IDX_BCN]   = 1'b1;
      load_per_o[IDX_DMA]   = 1'b1;
      load_per_o[IDX_TIM]   = 1'b1;
      load_per_o[IDX_DTIM]  = 1'b1;
      per_val_o[IDX_BCN]    = s_iv << TU_SHIFT;
      per_val_o[IDX_DMA]    = s_iv << TU_SHIFT;
      per_val_o[IDX_TIM]    = s_bi << TU_SHIFT;
      per_val_o[IDX_DTIM]   = s_dd << TU_SHIFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      lead_q  <= '0;
      corr_q  <= '0;
      stime_q <= '0;
    end else begin
      if (en_ce)    en_q    <= en_d;
      if (lead_ce)  lead_q  <= lead_d;
      if (corr_ce)  corr_q  <= corr_d;
      if (stime_ce) stime_q <= stime_d;
    end
  end

  assign en_o = en_q;

  assert_ap_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_APGO) |=>
      (en_q[2:0] == 3'b111) && (en_q[N-1:3] == $past(en_q[N-1:3])));
  assert_sta_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_STAGO) |=>
      (en_q[IDX_DMA] == 1'b0) && (en_q[IDX_SWA] == 1'b0) &&
      en_q[IDX_BCN] && en_q[IDX_TIM] && en_q[IDX_DTIM]);
endmodule

// File: rtl/beacon_timer_array.sv
module beacon_timer_array
  import bta_pkg::*;
#(
  parameter int W = TSF_W,
  parameter int N = NUM_TMR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick_i,
  input  logic              tsf_clear_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  output logic [N-1:0]      evt_pulse_o,
  output logic [W-1:0]      tsf_o
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [N-1:0]        load_next, load_per, en, hit;
  logic [N-1:0][W-1:0] next_val, per_val;
  logic                cfg_clr, tsf_clr;
  logic [W-1:0]        tsf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bta_cfg_decode #(.W(W), .N(N)) cfg_i (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .load_next_o(load_next), .next_val_o(next_val),
    .load_per_o(load_per), .per_val_o(per_val),
    .en_o(en), .tsf_clr_o(cfg_clr)
  );

  assign tsf_clr = cfg_clr | tsf_clear_i;

  bta_tsf_counter #(.W(W)) tsf_i (
    .clk(clk), .rst_n(rst_int_n),
    .tick_i(us_tick_i), .clr_i(tsf_clr), .tsf_o(tsf)
  );

  for (genvar g = 0; g < N; g++) begin : g_tmr
    bta_event_timer #(.W(W)) tmr_i (
      .clk(clk), .rst_n(rst_int_n), .en_i(en[g]), .tsf_i(tsf),
      .load_next_i(load_next[g]), .next_val_i(next_val[g]),
      .load_per_i(load_per[g]), .per_val_i(per_val[g]),
      .hit_o(hit[g])
    );
  end

  assign evt_pulse_o = hit;
  assign tsf_o       = tsf;

  assert_no_pulse_disabled_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (evt_pulse_o & ~en) == '0);
endmodule

// File: tb/beacon_timer_array_tb_top.sv
module beacon_timer_array_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        us_tick_i = 1'b0;
  logic        tsf_clear_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [4:0]  evt_pulse_o;
  logic [31:0] tsf_o;

  always #2.5 clk = ~clk;

  beacon_timer_array dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick_i(us_tick_i), .tsf_clear_i(tsf_clear_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .evt_pulse_o(evt_pulse_o), .tsf_o(tsf_o)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference state
  bit [31:0] m_tsf;
  bit [31:0] m_next [5];
  bit [31:0] m_per  [5];
  bit [4:0]  m_en;
  bit [31:0] m_lead, m_stime;
  bit [15:0] m_corr;

  int        pcnt [5];
  bit [31:0] first_ts [5];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_counts();
    for (int i = 0; i < 5; i++) begin pcnt[i] = 0; first_ts[i] = '0; end
  endtask

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  task automatic model_step(input bit wr, input bit [3:0] a, input bit [31:0] d,
                            input bit tk, input bit clr);
    bit [4:0] hits;
    bit       cfgclr = 0;
    for (int i = 0; i < 5; i++) hits[i] = m_en[i] && (m_tsf == m_next[i]);
    for (int i = 0; i < 5; i++) if (hits[i]) m_next[i] = m_next[i] + m_per[i];
    if (wr) begin
      if (a <= 4) m_next[a] = d;
      else if (a <= 9) m_per[a-5] = d;
      else if (a == 10) m_en = d[4:0];
      else if (a == 11) m_lead = d;
      else if (a == 12) m_corr = d[15:0];
      else if (a == 13) m_stime = d;
      else if (a == 14) begin
        int unsigned nb = d[31:16];
        int unsigned pp = d[15:1];
        m_next[0] = nb * 128;
        m_next[1] = nb * 128 - m_lead[15:0];
        m_next[2] = nb * 128 - m_lead[31:16];
        for (int i = 0; i < 3; i++) m_per[i] = pp * 128 + m_corr;
        cfgclr = d[0];
        m_en = m_en | 5'b00111;
      end else begin
        int unsigned iv = d[9:0];
        int unsigned dp = d[19:10];
        int unsigned sl = d[29:20];
        int unsigned bi = umax(iv, sl);
        int unsigned dd = umax(dp, sl);
        int unsigned nb = m_stime[15:0];
        int unsigned nd = m_stime[31:16];
        int unsigned nt = (bi == dd) ? nd : nb;
        m_next[0] = nb * 1024;  m_per[0] = iv * 1024;  m_per[1] = iv * 1024;
        m_next[3] = (nt - 3) * 1024;  m_per[3] = bi * 1024;
        m_next[4] = (nd - 3) * 1024;  m_per[4] = dd * 1024;
        m_en = (m_en & 5'b11001) | 5'b11001;
      end
    end
    if (clr || cfgclr) m_tsf = 0;
    else if (tk) m_tsf = m_tsf + 1;
  endtask

  // one cycle: drive at negedge, compare state-driven outputs, advance model
  task automatic cyc(input bit wr, input bit [3:0] a, input bit [31:0] d,
                     input bit tk, input bit clr);
    bit [4:0] exp_evt;
    wr_en_i = wr; wr_addr_i = a; wr_data_i = d; us_tick_i = tk; tsf_clear_i = clr;
    for (int i = 0; i < 5; i++) exp_evt[i] = m_en[i] && (m_tsf == m_next[i]);
    chk(evt_pulse_o == exp_evt, "R2", "evt_pulse_o", evt_pulse_o, exp_evt);
    chk(tsf_o == m_tsf, "R1", "tsf_o", tsf_o, m_tsf);
    for (int i = 0; i < 5; i++)
      if (evt_pulse_o[i]) begin
        if (pcnt[i] == 0) first_ts[i] = tsf_o;
        pcnt[i]++;
      end
    model_step(wr, a, d, tk, clr);
    @(negedge clk);
  endtask

  task automatic wr(input bit [3:0] a, input bit [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 4'd0, 32'd0, 1'b1, 1'b0);
  endtask

  initial begin
    m_tsf = 0; m_en = 0; m_lead = 0; m_stime = 0; m_corr = 0;
    for (int i = 0; i < 5; i++) begin m_next[i] = 0; m_per[i] = 0; end
    clear_counts();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk(evt_pulse_o == 5'b0, "R1", "reset evt", evt_pulse_o, 0);
    chk(tsf_o == 32'd0, "R1", "reset tsf", tsf_o, 0);

    // R2: raw periodic timer
    wr(4'd0, 32'd20); wr(4'd5, 32'd15); wr(4'd10, 32'd1);
    clear_counts();
    run(70);
    chk(pcnt[0] == 4, "R2", "beacon pulse count", pcnt[0], 4);
    chk(first_ts[0] == 20, "R2", "first beacon time", first_ts[0], 20);

    // R3: disabled timer silent and holds its next value (80)
    wr(4'd10, 32'd0);
    clear_counts();
    run(30);
    chk(pcnt[0] == 0, "R3", "pulses while disabled", pcnt[0], 0);
    cyc(1'b0, 4'd0, 32'd0, 1'b0, 1'b1);
    wr(4'd10, 32'd1);
    run(90);
    chk(first_ts[0] == 80, "R3", "held next after re-enable", first_ts[0], 80);

    // R4: write coincident with a match (next now 95, tsf 90)
    run(5);
    clear_counts();
    cyc(1'b1, 4'd0, 32'd102, 1'b1, 1'b0);
    chk(pcnt[0] == 1, "R4", "pulse on write cycle", pcnt[0], 1);
    clear_counts();
    run(25);
    chk(first_ts[0] == 102, "R4", "written value wins", first_ts[0], 102);
    chk(pcnt[0] == 2, "R4", "pulses after write", pcnt[0], 2);

    // R1: hold without tick, clear over tick
    cyc(1'b0, 4'd0, 32'd0, 1'b0, 1'b0);
    chk(tsf_o == m_tsf && m_tsf == 32'd121, "R1", "hold without tick", tsf_o, 121);
    cyc(1'b0, 4'd0, 32'd0, 1'b1, 1'b1);
    chk(tsf_o == 32'd0, "R1", "clear beats tick", tsf_o, 0);

    // R5 R6 R7: access-point command
    wr(4'd10, 32'd0);
    wr(4'd3, 32'h00F0_0000);
    wr(4'd11, {16'd300, 16'd100});
    wr(4'd12, 32'd5);
    wr(4'd10, 32'b01000);
    run(40);
    clear_counts();
    wr(4'd14, {16'd8, 15'd4, 1'b1});
    chk(tsf_o == 32'd0, "R7", "tsf cleared by command", tsf_o, 0);
    run(1600);
    chk(first_ts[0] == 1024, "R5", "beacon time", first_ts[0], 1024);
    chk(first_ts[1] == 924, "R5", "DMA alert time", first_ts[1], 924);
    chk(first_ts[2] == 724, "R5", "software alert time", first_ts[2], 724);
    chk(pcnt[0] == 2 && pcnt[1] == 2 && pcnt[2] == 2, "R6", "two periods of 517",
        pcnt[0] + pcnt[1] + pcnt[2], 6);
    chk(pcnt[3] == 0, "R7", "wake timer untouched", pcnt[3], 0);

    // R8 R9 R10: station command, no sleep extension
    wr(4'd10, 32'd0);
    wr(4'd13, {16'd8, 16'd4});
    cyc(1'b0, 4'd0, 32'd0, 1'b0, 1'b1);
    clear_counts();
    wr(4'd15, {2'b0, 10'd0, 10'd4, 10'd1});
    run(9300);
    chk(pcnt[1] == 0 && pcnt[2] == 0, "R8", "alerts off in station", pcnt[1] + pcnt[2], 0);
    chk(first_ts[0] == 4096 && pcnt[0] == 6, "R8", "beacon first time", first_ts[0], 4096);
    chk(first_ts[3] == 1024, "R9", "early wake B-3", first_ts[3], 1024);
    chk(first_ts[4] == 5120, "R9", "delivery wake D-3", first_ts[4], 5120);
    chk(pcnt[3] == 9, "R10", "wake period 1 TU", pcnt[3], 9);
    chk(pcnt[4] == 2, "R10", "delivery period 4 TU", pcnt[4], 2);

    // R9 R10: sleep duration extends the wake period and aligns to delivery
    wr(4'd10, 32'd0);
    cyc(1'b0, 4'd0, 32'd0, 1'b0, 1'b1);
    clear_counts();
    wr(4'd15, {2'b0, 10'd4, 10'd4, 10'd1});
    run(9300);
    chk(first_ts[3] == 5120, "R9", "aligned wake", first_ts[3], 5120);
    chk(pcnt[3] == 2, "R10", "wake period from sleep", pcnt[3], 2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule